// File: doc/BRIEF.md
# Calendar Clock with Frozen BCD Snapshot

This block keeps calendar time for a host on a byte-wide register bus. The time is held in eight binary counters: seconds, minutes, hours in 24-hour form, day of week, day of month, month, two-digit year and century. A one-cycle pulse on `sec_tick` advances these counters by one second. One clock later, all eight counters are converted to packed BCD and copied together into a host-visible snapshot. Each field and the control byte sit at a fixed byte offset, so the host needs no separate index and data port.

To read a coherent time, the host sets the hold bit in the control byte and then reads the fields. The snapshot stays unchanged while the counters keep counting. To set the time, the host sets the hold bit, writes the new BCD fields into the snapshot, and clears the hold bit. Clearing the hold bit loads the whole snapshot into the counters. A hold that arrives while a copy is pending lets that copy finish first.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the snapshot reads 00 seconds, 00 minutes, 00 hours, day of week 01, day of month 01, month 01, year 00 and century 20 (BCD), and the control byte reads 00.
- R2: A `sec_tick` pulse sampled at one clock edge advances the counters at that edge. At the following edge all eight snapshot fields are updated together.
- R3: While the hold bit is 1, the snapshot changes only through host writes. The hold bit is bit 3 of the control byte at offset 8. Ticks still advance the counters, so the time is correct after release.
- R4: Writes to offsets 0 to 7 while the hold bit is 0 are ignored. They change neither the snapshot nor the counters.
- R5: If the hold bit is written to 1 at the edge where a copy is pending, that copy still lands in the snapshot before it freezes.
- R6: If any field was written during the hold, clearing the hold bit loads all eight snapshot fields into the counters at that edge. If no field was written, clearing the hold bit leaves the counters untouched.
- R7: Seconds and minutes wrap after 59 and hours wrap after 23. Day of week runs 1 to 7 and steps once each time the day of month steps.
- R8: Day of month wraps to 1 after the month length (30 or 31 days, 28 in February), and month wraps from 12 to 1. February has 29 days when year mod 4 is 0 and the year is non-zero. For year 00, February has 29 days only when century mod 4 is 0.
- R9: Year wraps from 99 to 00 and carries one into the century, which wraps from 99 to 00.
- R10: Offsets 0 to 7 hold seconds, minutes, hours, day of week, day of month, month, year and century. Offset 8 is control, and every other offset reads 0. Reads return data in the same cycle, and writes take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |

## Verification
The in-module assertions check three things every cycle. The snapshot holds still during a hold except for host writes. It never moves while no copy is pending and the hold bit is clear. A load at release takes the snapshot values. The snapshot pulse also lasts exactly one cycle. The calendar arithmetic (month lengths, both leap rules, year and century carry) and the precedence of a pending copy over a newly requested hold are shown only by the bench's directed scenarios. The same holds for counters that keep running during a frozen read.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter logic [7:0] CENT_RST = 8'd20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);

  localparam logic [3:0] CTRL_OFS = 4'd8;
  localparam int HOLD_BIT = 3;

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] t, o;
    t = v / 8'd10;
    o = v % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  logic [7:0] sec_q, min_q, hr_q, dow_q, dom_q, mon_q, yr_q, cen_q;
  logic [7:0] shd [8];
  logic       hold_q, pend_q, dirty_q;
  logic [63:0] shd_flat;

  assign shd_flat = {shd[7], shd[6], shd[5], shd[4], shd[3], shd[2], shd[1], shd[0]};

  wire time_wr  = bus_wr && !bus_addr[3];
  wire ctrl_wr  = bus_wr && (bus_addr == CTRL_OFS);
  wire release_ev = hold_q && ctrl_wr && !bus_wdata[HOLD_BIT];
  wire do_load  = release_ev && dirty_q;
  wire do_xfer  = pend_q && !hold_q;

  logic leap;
  logic [7:0] mlen;
  always_comb begin
    if (yr_q != 8'd0) leap = (yr_q[1:0] == 2'd0);
    else              leap = (cen_q[1:0] == 2'd0);
    case (mon_q)
      8'd2:                      mlen = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   mlen = 8'd30;
      default:                   mlen = 8'd31;
    endcase
  end

  wire c_sec = (sec_q == 8'd59);
  wire c_min = c_sec && (min_q == 8'd59);
  wire c_hr  = c_min && (hr_q == 8'd23);
  wire c_day = c_hr && (dom_q >= mlen);
  wire c_mon = c_day && (mon_q == 8'd12);
  wire c_yr  = c_mon && (yr_q == 8'd99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'd0; min_q <= 8'd0; hr_q <= 8'd0; dow_q <= 8'd1;
      dom_q <= 8'd1; mon_q <= 8'd1; yr_q <= 8'd0; cen_q <= CENT_RST;
    end else if (do_load) begin
      sec_q <= from_bcd(shd[0]); min_q <= from_bcd(shd[1]);
      hr_q  <= from_bcd(shd[2]); dow_q <= from_bcd(shd[3]);
      dom_q <= from_bcd(shd[4]); mon_q <= from_bcd(shd[5]);
      yr_q  <= from_bcd(shd[6]); cen_q <= from_bcd(shd[7]);
    end else if (sec_tick) begin
      sec_q <= c_sec ? 8'd0 : sec_q + 8'd1;
      if (c_sec) min_q <= c_min ? 8'd0 : min_q + 8'd1;
      if (c_min) hr_q  <= c_hr ? 8'd0 : hr_q + 8'd1;
      if (c_hr) begin
        dow_q <= (dow_q >= 8'd7) ? 8'd1 : dow_q + 8'd1;
        dom_q <= c_day ? 8'd1 : dom_q + 8'd1;
      end
      if (c_day) mon_q <= c_mon ? 8'd1 : mon_q + 8'd1;
      if (c_mon) yr_q  <= c_yr ? 8'd0 : yr_q + 8'd1;
      if (c_yr)  cen_q <= (cen_q >= 8'd99) ? 8'd0 : cen_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      pend_q  <= 1'b0;
      dirty_q <= 1'b0;
      shd[0] <= 8'h00; shd[1] <= 8'h00; shd[2] <= 8'h00; shd[3] <= 8'h01;
      shd[4] <= 8'h01; shd[5] <= 8'h01; shd[6] <= 8'h00; shd[7] <= to_bcd(CENT_RST);
    end else begin
      pend_q <= sec_tick && !do_load;
      if (ctrl_wr) hold_q <= bus_wdata[HOLD_BIT];
      if (release_ev)              dirty_q <= 1'b0;
      else if (hold_q && time_wr)  dirty_q <= 1'b1;
      if (do_xfer) begin
        shd[0] <= to_bcd(sec_q); shd[1] <= to_bcd(min_q);
        shd[2] <= to_bcd(hr_q);  shd[3] <= to_bcd(dow_q);
        shd[4] <= to_bcd(dom_q); shd[5] <= to_bcd(mon_q);
        shd[6] <= to_bcd(yr_q);  shd[7] <= to_bcd(cen_q);
      end else if (hold_q && time_wr) begin
        shd[bus_addr[2:0]] <= bus_wdata;
      end
    end
  end

  assign bus_rdata = !bus_addr[3]            ? shd[bus_addr[2:0]] :
                     (bus_addr == CTRL_OFS)  ? {4'd0, hold_q, 3'd0} : 8'd0;

  a_r3_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !time_wr) |=> $stable(shd_flat));

  a_r4_unheld_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !pend_q) |=> $stable(shd_flat));

  a_r2_pend_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !sec_tick) |=> !pend_q);

  a_r6_release_load: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (sec_q == from_bcd($past(shd_flat[7:0]))) &&
                (cen_q == from_bcd($past(shd_flat[63:56]))));

endmodule

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_rtc_core dut_i (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s offset %0d: got %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dm, mo, y, c);
    wr(4'd8, 8'h08);
    wr(4'd0, s); wr(4'd1, mi); wr(4'd2, h); wr(4'd3, dw);
    wr(4'd4, dm); wr(4'd5, mo); wr(4'd6, y); wr(4'd7, c);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_reset();
    chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1"); chk(3, 8'h01, "R1");
    chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1"); chk(6, 8'h00, "R1"); chk(7, 8'h20, "R1");
    chk(8, 8'h00, "R1");
  endtask

  task automatic t_basic();
    tick(); tick(); tick();
    chk(0, 8'h03, "R2");
    chk(9, 8'h00, "R10"); chk(15, 8'h00, "R10");
  endtask

  task automatic t_freeze();
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
    tick();
    chk(0, 8'h11, "R6");
    wr(4'd0, 8'h45);
    chk(0, 8'h11, "R4");
    tick();
    chk(0, 8'h12, "R4");
    wr(4'd8, 8'h08);
    chk(8, 8'h08, "R10");
    for (int i = 0; i < 5; i++) tick();
    chk(0, 8'h12, "R3");
    wr(4'd8, 8'h00);
    tick();
    chk(0, 8'h18, "R3");
  endtask

  task automatic t_race();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    bus_addr = 4'd8; bus_wdata = 8'h08; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk(0, 8'h19, "R5");
    tick();
    chk(0, 8'h19, "R5");
    wr(4'd8, 8'h00);
    tick();
    chk(0, 8'h21, "R5");
  endtask

  task automatic t_rollover();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
    tick();
    chk(0, 8'h00, "R7"); chk(1, 8'h00, "R7"); chk(2, 8'h00, "R7"); chk(3, 8'h01, "R7");
    chk(4, 8'h01, "R8"); chk(5, 8'h01, "R8"); chk(6, 8'h00, "R9"); chk(7, 8'h21, "R9");
  endtask

  task automatic t_months();
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
    tick(); chk(4, 8'h29, "R8"); chk(5, 8'h02, "R8"); chk(3, 8'h04, "R7");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24, 8'h20);
    tick(); chk(4, 8'h01, "R8"); chk(5, 8'h03, "R8");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
    tick(); chk(4, 8'h01, "R8"); chk(5, 8'h03, "R8");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00, 8'h20);
    tick(); chk(4, 8'h29, "R8");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00, 8'h21);
    tick(); chk(4, 8'h01, "R8"); chk(5, 8'h03, "R8");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h25, 8'h20);
    tick(); chk(4, 8'h01, "R8"); chk(5, 8'h05, "R8");
    set_time(8'h59, 8'h58, 8'h10, 8'h03, 8'h30, 8'h05, 8'h25, 8'h20);
    tick(); chk(4, 8'h30, "R8"); chk(1, 8'h59, "R7"); chk(2, 8'h10, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_freeze();
    t_race();
    t_rollover();
    t_months();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule